// File: doc/BRIEF.md
# Bit-Stuffed Synchronous Frame Receiver

This block takes one serial data line, sampled whenever a bit-clock enable is high, and recovers frames of a bit-oriented synchronous link. It hunts for the delimiter pattern 01111110. It removes the zero that a transmitter inserts after every run of five ones, and assembles the surviving bits into octets, least significant bit first. The octets leave on a single-cycle byte strobe, and the first payload octet of each frame carries a start marker.

A CRC-CCITT check runs over every destuffed bit of the frame, including the two trailing check octets. Those two octets are never forwarded. When the closing delimiter arrives, exactly one status pulse appears. A good-frame pulse needs the fixed residue 0x1D0F and a whole number of octets, with at least the 16 check bits present. In any other case a bad-frame pulse appears. Two other events raise their own pulses. A long run of ones inside a frame is an abort. A delimiter followed by exactly seven ones and a zero is an end-of-poll signal, which tells a secondary station it may start sending. The block sits behind an external bit-clock recovery stage and ahead of whatever consumes the octets.

Top module: `bitframe_rx`

## Requirements
- R1: The pattern 01111110 (first bit on the left) is a delimiter. It both ends the current frame and opens the next. Two delimiters with no frame bits between them produce no byte and no status pulse.
- R2: Inside a frame, a 0 received right after five consecutive 1s is deleted, whatever its position relative to octet boundaries. The deleted bit neither reaches the octets nor enters the CRC.
- R3: Frame bits are packed into octets with the first received bit at bit 0. Each octet is one cycle of `out_valid` with the value on `out_data`. `out_sof` is high only together with the first octet of a frame. Two byte strobes are never on adjacent cycles.
- R4: The last 16 destuffed bits before the closing delimiter are the check field and are not delivered. A frame of N+2 whole octets delivers exactly its first N octets.
- R5: The CRC register uses x^16+x^12+x^5+1 and is preset to 0xFFFF at every delimiter. The frame bits enter it most significant end first, in the order received. A frame that is closed with the register at 0x1D0F, that holds a whole number of octets, and that has at least 16 bits raises `frame_good` for one cycle.
- R6: A frame whose register differs from 0x1D0F at the closing delimiter raises `frame_bad`. Its payload octets are still delivered.
- R7: A frame with fewer than 16 bits, or with a bit count that is not a multiple of 8, raises `frame_bad` at the closing delimiter.
- R8: Seven consecutive 1s inside a frame that already holds data bits raise `frame_abort`. No good or bad pulse follows for that frame, and octets not yet delivered are dropped.
- R9: After an abort, or after reset, the input is ignored until a delimiter is found.
- R10: A delimiter followed by exactly seven 1s and then a 0 raises `eop_seen` for one cycle, and not `frame_abort`. Eight or more 1s before the 0 raise nothing.
- R11: All outputs are registered. A status pulse appears on the clock edge that samples the deciding bit and lasts one cycle. At most one of the four status pulses is high at a time.
- R12: Synchronous active-high reset clears all outputs and puts the receiver in its hunting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one cycle per received bit |
| rx_bit | input | 1 | Serial line value, sampled when bit_en is high |
| out_valid | output | 1 | Payload octet strobe |
| out_data | output | 8 | Payload octet |
| out_sof | output | 1 | First octet of a frame |
| frame_good | output | 1 | Frame closed with a correct check and length |
| frame_bad | output | 1 | Frame closed with a check or length error |
| frame_abort | output | 1 | Frame terminated by a run of ones |
| eop_seen | output | 1 | End-of-poll sequence detected |

## Verification
A wrong run-length count would show up on the next frame as a missed or false delimiter. It would also show up as a shifted octet stream once a stuffed zero arrives, so frames full of 0xFF octets expose it within a few octets. A bad CRC preset or update step turns the very next good frame into a `frame_bad` pulse, one clock after its closing delimiter. Errors in the hold pipeline change how many octets a frame delivers, and a leftover state after an abort shows up as output on the traffic that follows it. A sweep over payload lengths, together with abort and poll sequences placed between frames, brings each of these to the ports within one frame.

// File: rtl/bitframe_pkg.sv
package bitframe_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY    = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'h1D0F;

  typedef enum logic {ST_HUNT, ST_ACTIVE} link_state_t;
endpackage

// File: rtl/bf_destuff.sv
module bf_destuff
  import bitframe_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  output logic dat_en,
  output logic dat_bit,
  output logic frm_open,
  output logic frm_close,
  output logic frm_abort,
  output logic eop_hit
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int DLY       = FLAG_RUN + 1;
  localparam int CNT_W     = $clog2(ABORT_RUN + 2);
  localparam int DC_W      = $clog2(DLY + 1);

  link_state_t      st_q, st_d;
  logic [CNT_W-1:0] ones_q, ones_d;
  logic [DLY-1:0]   dly_q, dly_d;
  logic [DC_W-1:0]  dcnt_q, dcnt_d;
  logic             has_q, has_d;
  logic             cand_q, cand_d;
  logic             push;

  always_comb begin
    st_d = st_q; ones_d = ones_q; dly_d = dly_q; dcnt_d = dcnt_q;
    has_d = has_q; cand_d = cand_q; push = 1'b0;
    dat_en = 1'b0; dat_bit = 1'b0;
    frm_open = 1'b0; frm_close = 1'b0; frm_abort = 1'b0; eop_hit = 1'b0;
    if (bit_en) begin
      if (rx_bit) begin
        if (ones_q < CNT_W'(ABORT_RUN + 1)) ones_d = ones_q + 1'b1;
        if (st_q == ST_ACTIVE) begin
          if (ones_q == CNT_W'(ABORT_RUN - 1)) begin
            st_d      = ST_HUNT;
            cand_d    = !has_q && (dcnt_q == DC_W'(FLAG_RUN));
            frm_abort = has_q || (dcnt_q != DC_W'(FLAG_RUN));
          end else begin
            push = 1'b1;
          end
        end
      end else begin
        ones_d = '0;
        cand_d = 1'b0;
        if (ones_q == CNT_W'(FLAG_RUN)) begin
          frm_close = (st_q == ST_ACTIVE) && has_q;
          frm_open  = 1'b1;
          st_d      = ST_ACTIVE;
          dcnt_d    = '0;
          has_d     = 1'b0;
        end else if (st_q == ST_HUNT) begin
          eop_hit = cand_q && (ones_q == CNT_W'(ABORT_RUN));
        end else if (ones_q != CNT_W'(STUFF_RUN)) begin
          push = 1'b1;
        end
      end
    end
    if (push) begin
      dly_d = {dly_q[DLY-2:0], rx_bit};
      if (dcnt_q == DC_W'(DLY)) begin
        dat_en  = 1'b1;
        dat_bit = dly_q[DLY-1];
        has_d   = 1'b1;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HUNT; ones_q <= '0; dly_q <= '0; dcnt_q <= '0;
      has_q <= 1'b0; cand_q <= 1'b0;
    end else begin
      st_q <= st_d; ones_q <= ones_d; dly_q <= dly_d; dcnt_q <= dcnt_d;
      has_q <= has_d; cand_q <= cand_d;
    end
  end

  assert_zero_clears_run_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !rx_bit) |=> (ones_q == '0));
  assert_abort_to_hunt_R9: assert property (@(posedge clk) disable iff (rst)
    frm_abort |=> (st_q == ST_HUNT));
endmodule

// File: rtl/bf_crc16.sv
module bf_crc16
  import bitframe_pkg::*;
#(
  parameter int W = CRC_W,
  parameter logic [W-1:0] POLY   = CRC_POLY,
  parameter logic [W-1:0] PRESET = CRC_PRESET
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic fb;
  assign fb = crc_q[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || init)  crc_q <= PRESET;
    else if (en)      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assert_preset_on_delim_R5: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc_q == PRESET));
endmodule

// File: rtl/bf_packer.sv
module bf_packer #(
  parameter int BYTE_W = 8,
  parameter int CHK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_en,
  input  logic              dat_bit,
  input  logic              frm_open,
  input  logic              frm_close,
  input  logic              frm_abort,
  input  logic              eop_hit,
  input  logic              crc_match,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              frame_good,
  output logic              frame_bad,
  output logic              frame_abort,
  output logic              eop_seen
);
  localparam int HOLD = CHK_W / BYTE_W;
  localparam int BC_W = $clog2(BYTE_W);
  localparam int HC_W = $clog2(HOLD + 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [BC_W-1:0]   bcnt_q;
  logic [HC_W-1:0]   hcnt_q;
  logic              first_q;
  logic [BYTE_W-1:0] byte_new;
  logic              frame_ok;

  assign byte_new = {dat_bit, shreg_q[BYTE_W-1:1]};
  assign frame_ok = crc_match && (bcnt_q == '0) && (hcnt_q == HC_W'(HOLD));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0;
      frame_good <= 1'b0; frame_bad <= 1'b0; frame_abort <= 1'b0; eop_seen <= 1'b0;
      shreg_q <= '0; bcnt_q <= '0; hcnt_q <= '0; first_q <= 1'b1;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0;
      frame_good <= 1'b0; frame_bad <= 1'b0; frame_abort <= 1'b0;
      eop_seen <= eop_hit;
      if (frm_open) begin
        frame_good <= frm_close && frame_ok;
        frame_bad  <= frm_close && !frame_ok;
        bcnt_q <= '0; hcnt_q <= '0; first_q <= 1'b1;
      end else if (frm_abort) begin
        frame_abort <= 1'b1;
        bcnt_q <= '0; hcnt_q <= '0;
      end else if (dat_en) begin
        shreg_q <= byte_new;
        if (bcnt_q == BC_W'(BYTE_W - 1)) begin
          bcnt_q <= '0;
          if (hcnt_q == HC_W'(HOLD)) begin
            out_valid <= 1'b1;
            out_data  <= hold_q[0];
            out_sof   <= first_q;
            first_q   <= 1'b0;
            for (int i = 0; i < HOLD - 1; i++) hold_q[i] <= hold_q[i+1];
            hold_q[HOLD-1] <= byte_new;
          end else begin
            for (int i = 0; i < HOLD; i++)
              if (hcnt_q == HC_W'(i)) hold_q[i] <= byte_new;
            hcnt_q <= hcnt_q + 1'b1;
          end
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assert_sof_with_byte_R3: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  assert_byte_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_good, frame_bad, frame_abort, eop_seen}));
endmodule

// File: rtl/bitframe_rx.sv
module bitframe_rx
  import bitframe_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              frame_good,
  output logic              frame_bad,
  output logic              frame_abort,
  output logic              eop_seen
);
  logic dat_en, dat_bit, frm_open, frm_close, frm_abort, eop_hit;
  logic [CRC_W-1:0] crc_q;

  bf_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .dat_en(dat_en), .dat_bit(dat_bit), .frm_open(frm_open),
    .frm_close(frm_close), .frm_abort(frm_abort), .eop_hit(eop_hit)
  );

  bf_crc16 u_crc (
    .clk(clk), .rst(rst), .init(frm_open), .en(dat_en), .din(dat_bit),
    .crc_q(crc_q)
  );

  bf_packer #(.BYTE_W(BYTE_W), .CHK_W(CRC_W)) u_packer (
    .clk(clk), .rst(rst), .dat_en(dat_en), .dat_bit(dat_bit),
    .frm_open(frm_open), .frm_close(frm_close), .frm_abort(frm_abort),
    .eop_hit(eop_hit), .crc_match(crc_q == CRC_RESIDUE),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .frame_good(frame_good), .frame_bad(frame_bad),
    .frame_abort(frame_abort), .eop_seen(eop_seen)
  );
endmodule

// File: tb/bitframe_rx_tb.sv
`timescale 1ns/1ps
module bitframe_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b1;
  logic       out_valid, out_sof, frame_good, frame_bad, frame_abort, eop_seen;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  bitframe_rx u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .frame_good(frame_good), .frame_bad(frame_bad),
    .frame_abort(frame_abort), .eop_seen(eop_seen)
  );

  int checks = 0, fails = 0;
  int n_bytes = 0, n_good = 0, n_bad = 0, n_abort = 0, n_eop = 0;
  logic [7:0] got [0:255];
  logic       got_sof [0:255];

  always @(negedge clk) if (!rst) begin
    if (out_valid) begin
      got[n_bytes[7:0]] = out_data;
      got_sof[n_bytes[7:0]] = out_sof;
      n_bytes++;
    end
    if (frame_good)  n_good++;
    if (frame_bad)   n_bad++;
    if (frame_abort) n_abort++;
    if (eop_seen)    n_eop++;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int tx_ones = 0;
  logic [15:0] tx_crc = 16'hFFFF;
  int flip_at = -1, bit_idx = 0;
  logic [7:0] pay [0:31];
  int b_bytes, b_good, b_bad, b_abort, b_eop;

  task automatic raw(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic stuffed(input logic b);
    raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic flag();
    raw(1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    raw(1'b0);
    tx_ones = 0; tx_crc = 16'hFFFF; bit_idx = 0;
  endtask

  task automatic data_bit(input logic b);
    logic fb;
    fb = tx_crc[15] ^ b;
    tx_crc = {tx_crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    stuffed(b ^ (bit_idx == flip_at));
    bit_idx++;
  endtask

  task automatic data_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) data_bit(v[i]);
  endtask

  task automatic send_fcs();
    logic [15:0] f;
    f = ~tx_crc;
    for (int i = 15; i >= 0; i--) stuffed(f[i]);
  endtask

  task automatic snap();
    b_bytes = n_bytes; b_good = n_good; b_bad = n_bad; b_abort = n_abort; b_eop = n_eop;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input int extra);
    flag();
    for (int i = 0; i < n; i++) data_byte(pay[i]);
    for (int i = 0; i < extra; i++) data_bit(i[0]);
    send_fcs();
    flag();
    settle();
  endtask

  task automatic check_payload(input string tag, input int n);
    int bad_data, bad_sof;
    bad_data = 0; bad_sof = 0;
    for (int i = 0; i < n; i++) begin
      if (got[(b_bytes + i) % 256] != pay[i]) bad_data++;
      if (got_sof[(b_bytes + i) % 256] != (i == 0)) bad_sof++;
    end
    check_eq({tag, " byte mismatches"}, bad_data, 0);
    check_eq({tag, " sof misplaced"}, bad_sof, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check_eq("R12 outputs after reset",
             int'({out_valid, out_sof, frame_good, frame_bad, frame_abort, eop_seen, out_data}), 0);

    // R9 input before any delimiter is ignored; R1 empty delimiters report nothing
    snap();
    for (int i = 0; i < 20; i++) raw(i[2]);
    for (int i = 0; i < 3; i++) flag();
    settle();
    check_eq("R9 pre-delimiter bytes", n_bytes - b_bytes, 0);
    check_eq("R1 empty delimiters status",
             (n_good - b_good) + (n_bad - b_bad) + (n_abort - b_abort), 0);

    // R2 R3 R4 R5 sweep over lengths and stuffing-heavy patterns
    for (int p = 0; p < 3; p++) begin
      for (int n = 0; n <= 8; n++) begin
        for (int i = 0; i < n; i++)
          pay[i] = (p == 0) ? 8'((n * 37 + i * 91) & 8'hFF) :
                   (p == 1) ? 8'hFF : (i[0] ? 8'h3F : 8'h7E);
        snap();
        send_frame(n, 0);
        check_eq($sformatf("R5 good p%0d n%0d", p, n), n_good - b_good, 1);
        check_eq($sformatf("R5 no bad p%0d n%0d", p, n), n_bad - b_bad, 0);
        check_eq($sformatf("R4 byte count p%0d n%0d", p, n), n_bytes - b_bytes, n);
        check_payload($sformatf("R2 R3 p%0d n%0d", p, n), n);
      end
    end

    // R6 corrupted bit: bad status, payload still delivered
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'h21 * (i + 1));
    snap();
    flip_at = 13;
    send_frame(4, 0);
    flip_at = -1;
    check_eq("R6 bad on crc error", n_bad - b_bad, 1);
    check_eq("R6 no good on crc error", n_good - b_good, 0);
    check_eq("R6 bytes still delivered", n_bytes - b_bytes, 4);

    // R7 misaligned length
    snap();
    send_frame(3, 3);
    check_eq("R7 misaligned bad", n_bad - b_bad, 1);
    check_eq("R7 misaligned no good", n_good - b_good, 0);

    // R7 short frame
    snap();
    flag(); data_byte(8'h5A); flag(); settle();
    check_eq("R7 short bad", n_bad - b_bad, 1);
    check_eq("R7 short no bytes", n_bytes - b_bytes, 0);

    // R8 abort mid-frame
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44; pay[4] = 8'h00;
    snap();
    flag();
    for (int i = 0; i < 5; i++) data_byte(pay[i]);
    for (int i = 0; i < 7; i++) raw(1'b1);
    settle();
    check_eq("R8 abort pulse", n_abort - b_abort, 1);
    check_eq("R8 no close status", (n_good - b_good) + (n_bad - b_bad), 0);
    check_eq("R8 bytes before abort", n_bytes - b_bytes, 2);
    check_payload("R8", 2);

    // R9 traffic after abort is ignored until a delimiter
    snap();
    for (int i = 0; i < 4; i++) begin
      data_byte(8'h00); data_byte(8'h55);
    end
    settle();
    check_eq("R9 ignored bytes", n_bytes - b_bytes, 0);
    check_eq("R9 ignored status",
             (n_good - b_good) + (n_bad - b_bad) + (n_abort - b_abort) + (n_eop - b_eop), 0);
    pay[0] = 8'hC3; pay[1] = 8'h0F;
    snap();
    send_frame(2, 0);
    check_eq("R9 recovery good", n_good - b_good, 1);
    check_payload("R9 recovery", 2);

    // R10 end-of-poll, R11 timing of the pulse
    snap();
    flag();
    for (int i = 0; i < 7; i++) raw(1'b1);
    raw(1'b0);
    check_eq("R11 eop pulse on deciding edge", int'(eop_seen), 1);
    @(negedge clk);
    check_eq("R11 eop pulse one cycle", int'(eop_seen), 0);
    settle();
    check_eq("R10 eop count", n_eop - b_eop, 1);
    check_eq("R10 eop is no abort", n_abort - b_abort, 0);

    snap();
    flag();
    for (int i = 0; i < 8; i++) raw(1'b1);
    raw(1'b0);
    settle();
    check_eq("R10 eight ones no eop", n_eop - b_eop, 0);
    check_eq("R10 eight ones no abort", n_abort - b_abort, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule